// File: doc/BRIEF.md
# Differential escalation link transmitter with liveness ping

This block sends one escalation command across a complementary wire pair to a remote receiver and watches the complementary reply pair that the receiver drives back. The same outgoing pair also carries a liveness test. A test (ping) is a pulse that lasts exactly one clock. A real escalation always lasts two clocks or more. The receiver tells the two apart by pulse length alone, and the transmitter enforces that length rule on whatever its requester does.

The transmitter checks every reply it expects. After a ping, the receiver must return a fixed alternating pattern over four clocks, and the transmitter then issues either a ping-good pulse or a reply-error pulse. While escalation is asserted, the reply pair must keep toggling, and a missed toggle raises the reply-error pulse. In any clock where the two reply wires carry equal levels, the pair is broken, and a registered integrity-error pulse follows. If escalation is requested in the same clock as a ping, or while a ping is still waiting for its reply, escalation wins and the ping is dropped without a verdict.

Top module: `esc_link_tx`

## Requirements
- R1: Reset is synchronous and active high. During reset and afterwards while idle, `esc_p_o`=0, `esc_n_o`=1, and `ping_ok_o`, `resp_err_o` and `integ_err_o` are all 0.
- R2: A ping request taken in idle clock t drives `esc_p_o`=1 and `esc_n_o`=0 in clock t+1 only.
- R3: If `esc_req_i` is high for L consecutive clocks starting at clock t, the pair is asserted from clock t+1 through clock t+max(L,2). It returns to idle in the following clock.
- R4: Escalation has priority. If `esc_req_i` and `ping_req_i` are high in the same clock, escalation starts. If `esc_req_i` goes high while a ping waits for its reply, the ping is dropped and produces neither `ping_ok_o` nor a reply-error from its window.
- R5: A ping request is ignored while a ping pulse or its reply window is in progress. With `ping_req_i` held high, the next pulse comes 6 clocks after the previous one.
- R6: Call the ping pulse clock c0. The expected reply in clocks c1..c4 is `resp_p_i` = 1,0,1,0, with `resp_n_i` equal to its complement. If all four clocks match, `ping_ok_o` is high for exactly clock c5.
- R7: If any of the four reply clocks mismatches, `resp_err_o` is high in clock c5 and `ping_ok_o` stays low.
- R8: Consider any clock that follows a clock with `esc_p_o`=1 and that lies outside a ping reply window. In such a clock, `resp_p_i` must differ from its value one clock earlier; otherwise `resp_err_o` is high in the next clock.
- R9: In any clock where `resp_p_i` equals `resp_n_i`, `integ_err_o` is high in the next clock. A single such clock gives a single-clock pulse.
- R10: `esc_n_o` is always the complement of `esc_p_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| esc_req_i | input | 1 | Escalation request level |
| ping_req_i | input | 1 | Ping request |
| resp_p_i | input | 1 | Reply pair, true wire |
| resp_n_i | input | 1 | Reply pair, complement wire |
| esc_p_o | output | 1 | Outgoing pair, true wire |
| esc_n_o | output | 1 | Outgoing pair, complement wire |
| ping_ok_o | output | 1 | Pulse: ping reply matched |
| resp_err_o | output | 1 | Pulse: reply pattern or toggle failure |
| integ_err_o | output | 1 | Pulse: reply wires were equal |

## Verification
Escalation and the ping reply check can land in the same clock. The bench raises `esc_req_i` together with a ping request, and also at each of the four reply clocks. It then expects the pair to stay asserted for the escalation length and no ping verdict of either kind to appear. The bench also injects a single-wire flip inside a ping window, and in that case expects both the integrity pulse in the next clock and the reply-error pulse at c5. The reply pair comes from a small behavioural receiver in the bench, with fault masks placed on top of its outputs.

// File: rtl/esc_link_pkg.sv
package esc_link_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_RWAIT = 2'd2,
        ST_ESC   = 2'd3
    } link_st_e;

    typedef struct packed {
        logic p;
        logic n;
    } diff_pair_t;

    typedef struct packed {
        logic ping_ok;
        logic resp_err;
        logic integ_err;
    } link_flags_t;

    // Expected true-wire reply at window position k (1-based): odd -> 1.
    function automatic logic exp_resp_p(input logic [7:0] k);
        return k[0];
    endfunction

    function automatic logic pair_broken(input diff_pair_t d);
        return d.p == d.n;
    endfunction

endpackage

// File: rtl/esc_link_fsm.sv
module esc_link_fsm
    import esc_link_pkg::*;
#(
    parameter int RESP_LEN = 4,
    parameter int MIN_ESC  = 2,
    localparam int IDXW    = $clog2(RESP_LEN + 1),
    localparam int HOLDW   = $clog2(MIN_ESC + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            esc_req_i,
    input  logic            ping_req_i,
    output link_st_e        state_o,
    output logic [IDXW-1:0] win_idx_o,
    output logic            win_done_o,
    output diff_pair_t      pair_o
);

    link_st_e         state_q, state_d;
    logic [IDXW-1:0]  idx_q, idx_d;
    logic [HOLDW-1:0] hold_q, hold_d;
    logic             esc_p_q, esc_n_q, drive_d;

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        hold_d  = hold_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ping_req_i) begin
                    state_d = ST_PULSE;
                end
            end
            ST_PULSE: begin
                state_d = ST_RWAIT;
                idx_d   = IDXW'(1);
            end
            ST_RWAIT: begin
                if (idx_q == IDXW'(RESP_LEN)) begin
                    state_d = ST_IDLE;
                    idx_d   = '0;
                end else begin
                    idx_d = idx_q + IDXW'(1);
                end
            end
            ST_ESC: begin
                if (hold_q != '0) begin
                    hold_d = hold_q - HOLDW'(1);
                end else if (!esc_req_i) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase

        // escalation overrides everything, including a pending ping window
        if (esc_req_i && state_q != ST_ESC) begin
            state_d = ST_ESC;
            idx_d   = '0;
            hold_d  = HOLDW'(MIN_ESC - 1);
        end
    end

    assign drive_d = (state_d == ST_PULSE) || (state_d == ST_ESC);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            hold_q  <= '0;
            esc_p_q <= 1'b0;
            esc_n_q <= 1'b1;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            hold_q  <= hold_d;
            esc_p_q <= drive_d;
            esc_n_q <= !drive_d;
        end
    end

    assign state_o    = state_q;
    assign win_idx_o  = idx_q;
    assign win_done_o = (state_q == ST_RWAIT) && (idx_q == IDXW'(RESP_LEN)) && !esc_req_i;
    assign pair_o     = '{p: esc_p_q, n: esc_n_q};

    // R2: a ping pulse lasts one clock; next clock is the window or escalation
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PULSE) |=> (state_q == ST_RWAIT || state_q == ST_ESC));

    // R3: a freshly entered escalation is held for a second clock
    a_r3_min_length: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ESC && $past(state_q) != ST_ESC) |=> (state_q == ST_ESC));

    // R5: no new ping pulse directly out of a reply window
    a_r5_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RWAIT) |=> (state_q != ST_PULSE));

    // R10: the two outgoing wires are always complementary
    a_r10_pair_complement: assert property (@(posedge clk) disable iff (rst)
        esc_p_q != esc_n_q);

endmodule

// File: rtl/esc_link_resp_chk.sv
module esc_link_resp_chk
    import esc_link_pkg::*;
#(
    parameter int RESP_LEN = 4,
    localparam int IDXW    = $clog2(RESP_LEN + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  link_st_e        state_i,
    input  logic [IDXW-1:0] win_idx_i,
    input  logic            win_done_i,
    input  logic            esc_drive_i,
    input  diff_pair_t      resp_i,
    output link_flags_t     flags_o
);

    logic acc_bad_q, mis_now, ping_bad, tog_bad;
    logic prev_esc_q, prev_rp_q;
    link_flags_t flags_q;

    // pattern mismatch in the current reply-window clock
    always_comb begin
        mis_now = 1'b0;
        if (state_i == ST_RWAIT) begin
            mis_now = (resp_i.p != exp_resp_p(8'(win_idx_i))) ||
                      (resp_i.n != !exp_resp_p(8'(win_idx_i)));
        end
    end

    assign ping_bad = win_done_i && (acc_bad_q || mis_now);
    assign tog_bad  = prev_esc_q && (state_i != ST_RWAIT) && (resp_i.p == prev_rp_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_bad_q  <= 1'b0;
            prev_esc_q <= 1'b0;
            prev_rp_q  <= 1'b0;
            flags_q    <= '0;
        end else begin
            if (state_i == ST_PULSE) begin
                acc_bad_q <= 1'b0;
            end else if (state_i == ST_RWAIT) begin
                acc_bad_q <= acc_bad_q || mis_now;
            end
            prev_esc_q         <= esc_drive_i;
            prev_rp_q          <= resp_i.p;
            flags_q.ping_ok    <= win_done_i && !(acc_bad_q || mis_now);
            flags_q.resp_err   <= ping_bad || tog_bad;
            flags_q.integ_err  <= pair_broken(resp_i);
        end
    end

    assign flags_o = flags_q;

    // R6/R7: a ping verdict is either good or bad, never both
    a_r7_verdict_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(flags_q.ping_ok && flags_q.resp_err));

    // R6: a good-ping pulse only follows the last window clock
    a_r6_ok_after_window: assert property (@(posedge clk) disable iff (rst)
        flags_q.ping_ok |-> ($past(state_i) == ST_RWAIT));

endmodule

// File: rtl/esc_link_tx.sv
module esc_link_tx
    import esc_link_pkg::*;
#(
    parameter int RESP_LEN = 4,
    parameter int MIN_ESC  = 2,
    localparam int IDXW    = $clog2(RESP_LEN + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic esc_req_i,
    input  logic ping_req_i,
    input  logic resp_p_i,
    input  logic resp_n_i,
    output logic esc_p_o,
    output logic esc_n_o,
    output logic ping_ok_o,
    output logic resp_err_o,
    output logic integ_err_o
);

    link_st_e        state;
    logic [IDXW-1:0] win_idx;
    logic            win_done;
    diff_pair_t      pair;
    diff_pair_t      resp;
    link_flags_t     flags;

    assign resp = '{p: resp_p_i, n: resp_n_i};

    esc_link_fsm #(
        .RESP_LEN (RESP_LEN),
        .MIN_ESC  (MIN_ESC)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .esc_req_i  (esc_req_i),
        .ping_req_i (ping_req_i),
        .state_o    (state),
        .win_idx_o  (win_idx),
        .win_done_o (win_done),
        .pair_o     (pair)
    );

    esc_link_resp_chk #(
        .RESP_LEN (RESP_LEN)
    ) u_chk (
        .clk         (clk),
        .rst         (rst),
        .state_i     (state),
        .win_idx_i   (win_idx),
        .win_done_i  (win_done),
        .esc_drive_i (pair.p),
        .resp_i      (resp),
        .flags_o     (flags)
    );

    assign esc_p_o     = pair.p;
    assign esc_n_o     = pair.n;
    assign ping_ok_o   = flags.ping_ok;
    assign resp_err_o  = flags.resp_err;
    assign integ_err_o = flags.integ_err;

    // R9: equal reply wires are reported in the following clock
    a_r9_integrity_flag: assert property (@(posedge clk) disable iff (rst)
        (resp_p_i == resp_n_i) |=> integ_err_o);

    // R4: escalation requested from idle asserts the pair next clock
    a_r4_esc_priority: assert property (@(posedge clk) disable iff (rst)
        (esc_req_i && ping_req_i) |=> esc_p_o);

endmodule

// File: tb/esc_link_tx_tb_top.sv
`timescale 1ns/1ps
module esc_link_tx_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic esc_req = 1'b0, ping_req = 1'b0;
    logic fp = 1'b0, fn = 1'b0;
    logic rp, rn;
    int   rx_st;
    logic esc_p, esc_n, ping_ok, resp_err, integ_err;
    int   n_chk = 0, n_fail = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    esc_link_tx dut_i (
        .clk(clk), .rst(rst), .esc_req_i(esc_req), .ping_req_i(ping_req),
        .resp_p_i(rp ^ fp), .resp_n_i(rn ^ fn),
        .esc_p_o(esc_p), .esc_n_o(esc_n), .ping_ok_o(ping_ok),
        .resp_err_o(resp_err), .integ_err_o(integ_err)
    );

    // behavioural far-end receiver
    always @(posedge clk) begin
        if (rst) begin
            rx_st <= 0; rp <= 1'b0; rn <= 1'b1;
        end else begin
            case (rx_st)
                0: if (esc_p && !esc_n) begin rx_st <= 1; rp <= ~rp; rn <= rp; end
                   else begin rp <= 1'b0; rn <= 1'b1; end
                1: begin rp <= ~rp; rn <= rp; rx_st <= (esc_p && !esc_n) ? 3 : 2; end
                2: begin rp <= ~rp; rn <= rp; rx_st <= (esc_p && !esc_n) ? 3 : 0; end
                default: if (esc_p && !esc_n) begin rp <= ~rp; rn <= rp; end
                         else begin rx_st <= 0; rp <= 1'b0; rn <= 1'b1; end
            endcase
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic good_ping();
        ping_req = 1'b1; step(); ping_req = 1'b0;
        chk("R2 pulse p", esc_p, 1'b1); chk("R10 pulse n", esc_n, 1'b0);
        step();
        chk("R2 pulse ends", esc_p, 1'b0);
        step(4);
        chk("R6 ping ok", ping_ok, 1'b1); chk("R7 no err", resp_err, 1'b0);
        step();
        chk("R6 ok single", ping_ok, 1'b0);
    endtask

    initial begin
        step(3);
        chk("R1 rst p", esc_p, 1'b0); chk("R1 rst n", esc_n, 1'b1);
        chk("R1 rst ok", ping_ok, 1'b0); chk("R1 rst err", resp_err, 1'b0);
        rst = 1'b0;
        step(2);
        chk("R1 idle p", esc_p, 1'b0); chk("R1 idle integ", integ_err, 1'b0);

        good_ping();
        step(2);

        // R7 / R9: single-wire flip at every window position
        for (int k = 1; k <= 4; k++) begin
            for (int w = 0; w < 2; w++) begin
                ping_req = 1'b1; step(); ping_req = 1'b0;
                step(k);
                if (w == 0) fp = 1'b1; else fn = 1'b1;
                step();
                fp = 1'b0; fn = 1'b0;
                chk("R9 integ in window", integ_err, 1'b1);
                step(4 - k);
                chk("R7 err", resp_err, 1'b1); chk("R7 no ok", ping_ok, 1'b0);
                step(2);
            end
        end

        // R3 / R8 / R10: escalation length sweep
        for (int len = 1; len <= 6; len++) begin
            int hi;
            hi = (len < 2) ? 2 : len;
            esc_req = 1'b1;
            for (int j = 1; j <= len + 3; j++) begin
                step();
                if (j == len) esc_req = 1'b0;
                chk("R3 length", esc_p, (j <= hi));
                chk("R10 compl", esc_n, !(j <= hi));
                chk("R8 toggles", resp_err, 1'b0);
            end
            good_ping();
            step();
        end

        // R8: broken toggle during escalation
        esc_req = 1'b1; step(4);
        fp = 1'b1; fn = 1'b1; step(); fp = 1'b0; fn = 1'b0;
        chk("R8 toggle err", resp_err, 1'b1); chk("R9 pair fine", integ_err, 1'b0);
        esc_req = 1'b0; step(6);
        chk("R8 err clears", resp_err, 1'b0);

        // R4: same-clock priority
        esc_req = 1'b1; ping_req = 1'b1; step(); esc_req = 1'b0; ping_req = 1'b0;
        chk("R4 esc p", esc_p, 1'b1);
        step(); chk("R4 held", esc_p, 1'b1);
        step(); chk("R4 released", esc_p, 1'b0);
        for (int j = 0; j < 5; j++) begin
            step(); chk("R4 no ok", ping_ok, 1'b0); chk("R4 no err", resp_err, 1'b0);
        end

        // R4: escalation during each reply clock abandons the ping
        for (int k = 1; k <= 4; k++) begin
            ping_req = 1'b1; step(); ping_req = 1'b0;
            step(k);
            esc_req = 1'b1; step(); esc_req = 1'b0;
            chk("R4 abort esc", esc_p, 1'b1);
            for (int j = 0; j < 7; j++) begin
                step();
                chk("R4 abort no ok", ping_ok, 1'b0);
                chk("R4 abort no err", resp_err, 1'b0);
            end
        end

        // R5: held ping request
        ping_req = 1'b1; step();
        chk("R5 first", esc_p, 1'b1);
        for (int j = 1; j <= 6; j++) begin
            step();
            chk("R5 spacing", esc_p, (j == 6));
            if (j == 5) chk("R6 first ok", ping_ok, 1'b1);
        end
        ping_req = 1'b0;
        step(5);
        chk("R6 second ok", ping_ok, 1'b1);
        step(2);

        // R9: broken reply pair while idle
        fp = 1'b1; step(); fp = 1'b0;
        chk("R9 idle integ", integ_err, 1'b1); chk("R9 no resp err", resp_err, 1'b0);
        step(); chk("R9 single", integ_err, 1'b0);
        fn = 1'b1; step(); fn = 1'b0;
        chk("R9 n wire", integ_err, 1'b1);
        step(2);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule